// File: doc/BRIEF.md
# Section Copy Table Loader

This block moves program sections into place at boot. It is given the address of a copy table in memory. It reads the program entry word first. It then walks the records that follow. Each record names a byte size, a source address where the section is stored, and a destination address where it will execute. The block copies the words of each record and stops at the first record whose size is zero. It then reports completion and presents the stored entry word so that the processor can branch to it.

A single memory master port carries both reads and writes. The port keeps one access in flight at a time. A request stays up until the memory grants it. A read is complete only when the read data comes back marked valid.

Top module: `section_loader`

## Requirements
- R1: After reset, `done`, `busy` and `mem_req` are all 0.
- R2: A `start` pulse while idle samples `tbl_base` and reads the 32-bit entry word at `tbl_base`. Each record then holds three words: size at +4, source at +8 and destination at +12, counted from the record start. The next record follows 12 bytes later.
- R3: For every record, each word is read at the source and then written with the same data at the destination. Both addresses rise by 4 per word, in increasing order.
- R4: A record with size 0 ends the table and causes no copy. A table holding only the entry word and a zero size issues no writes at all.
- R5: Size is a byte count rounded up to whole 4-byte words. Sizes 1 to 4 copy one word, 5 to 8 copy two words, and so on. The word just past the rounded count is left unchanged.
- R6: `done` is high for exactly one cycle, in the cycle after the read data of the terminating size word is accepted. In that cycle `jump_addr` equals the entry word read from the table.
- R7: `start` is ignored while `busy` is high. A second pulse with another base does not change the access sequence.
- R8: Only one access is in flight. After a read is granted, no new request is raised until its read data has returned. A request that is not granted keeps its address, direction and write data unchanged in the next cycle.
- R9: `busy` rises in the cycle after an accepted `start`. It stays high through the `done` cycle and falls right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a table walk (taken only when idle) |
| tbl_base | input | 32 | Byte address of the copy table |
| mem_req | output | 1 | Access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted in this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| jump_addr | output | 32 | Program entry address from the table |
| busy | output | 1 | A table walk is in progress |

## Verification
The bench runs several tables:
- A three-record table with sizes 8, 5 and 1. It checks record stepping and rounding.
- A table that ends right after its entry word. It checks that a zero size alone produces no write.
- A table with sizes 3, 4 and 12. It checks the rounding edges.

The first table is run once with zero-wait grants and single-cycle read latency, and once with pseudo-random grant stalls and read latencies. This separates the address sequencing from correct waiting on the handshakes. A second `start` with a different base is raised in the middle of one run, which shows whether a start is wrongly taken while busy. Destination words past each rounded size are checked to be unchanged.

// File: rtl/loader_pkg.sv
package loader_pkg;
    localparam int unsigned LD_ADDR_W = 32;
    localparam int unsigned LD_WORD_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENTRY,
        ST_SIZE,
        ST_SRC,
        ST_DST,
        ST_CPRD,
        ST_CPWR,
        ST_FIN
    } ld_state_e;
endpackage

// File: rtl/loader_sizer.sv
module loader_sizer #(
    parameter int unsigned DW    = 32,
    parameter int unsigned BYTES = DW / 8,
    localparam int unsigned BW   = $clog2(BYTES),
    localparam int unsigned CW   = DW - BW + 1
) (
    input  logic [DW-1:0] size_bytes,
    output logic [CW-1:0] size_words,
    output logic          size_zero
);
    always_comb begin
        size_words = {1'b0, size_bytes[DW-1:BW]} + CW'(|size_bytes[BW-1:0]);
        size_zero  = (size_bytes == '0);
    end
endmodule

// File: rtl/loader_mem_if.sv
module loader_mem_if #(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic          cmd_we,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    output logic          cmd_done,
    output logic [DW-1:0] cmd_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_gnt,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata
);
    logic wait_d, wait_q;

    always_comb begin
        wait_d    = wait_q;
        mem_req   = cmd_valid && !wait_q;
        mem_we    = cmd_we;
        mem_addr  = cmd_addr;
        mem_wdata = cmd_wdata;
        cmd_rdata = mem_rdata;
        cmd_done  = 1'b0;
        if (wait_q) begin
            if (mem_rvalid) begin
                cmd_done = 1'b1;
                wait_d   = 1'b0;
            end
        end else if (mem_req && mem_gnt) begin
            if (cmd_we) cmd_done = 1'b1;
            else        wait_d   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wait_q <= 1'b0;
        else        wait_q <= wait_d;
    end

    p_one_in_flight_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt && !mem_we) |=> !mem_req);

    p_req_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));
endmodule

// File: rtl/section_loader.sv
module section_loader
    import loader_pkg::*;
#(
    parameter int unsigned AW = LD_ADDR_W,
    parameter int unsigned DW = LD_WORD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] tbl_base,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_gnt,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata,
    output logic          done,
    output logic [AW-1:0] jump_addr,
    output logic          busy
);
    localparam int unsigned BYTES = DW / 8;
    localparam int unsigned BW    = $clog2(BYTES);
    localparam int unsigned CW    = DW - BW + 1;
    localparam logic [AW-1:0] STEP = AW'(BYTES);

    typedef struct packed {
        ld_state_e     state;
        logic [AW-1:0] ptr;
        logic [AW-1:0] entry;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [CW-1:0] remain;
        logic [DW-1:0] data;
    } regs_t;

    regs_t r_d, r_q;

    logic          cmd_valid, cmd_we, cmd_done;
    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] cmd_rdata;
    logic [CW-1:0] rec_words;
    logic          rec_zero;

    loader_mem_if #(.AW(AW), .DW(DW)) mem_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_we(cmd_we), .cmd_addr(cmd_addr),
        .cmd_wdata(r_q.data), .cmd_done(cmd_done), .cmd_rdata(cmd_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata)
    );

    loader_sizer #(.DW(DW), .BYTES(BYTES)) size_i (
        .size_bytes(cmd_rdata), .size_words(rec_words), .size_zero(rec_zero)
    );

    always_comb begin
        r_d       = r_q;
        cmd_valid = 1'b0;
        cmd_we    = 1'b0;
        cmd_addr  = r_q.ptr;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.ptr   = tbl_base;
                    r_d.state = ST_ENTRY;
                end
            end
            ST_ENTRY: begin
                cmd_valid = 1'b1;
                if (cmd_done) begin
                    r_d.entry = cmd_rdata;
                    r_d.ptr   = r_q.ptr + STEP;
                    r_d.state = ST_SIZE;
                end
            end
            ST_SIZE: begin
                cmd_valid = 1'b1;
                if (cmd_done) begin
                    if (rec_zero) begin
                        r_d.state = ST_FIN;
                    end else begin
                        r_d.remain = rec_words;
                        r_d.ptr    = r_q.ptr + STEP;
                        r_d.state  = ST_SRC;
                    end
                end
            end
            ST_SRC: begin
                cmd_valid = 1'b1;
                if (cmd_done) begin
                    r_d.src   = cmd_rdata;
                    r_d.ptr   = r_q.ptr + STEP;
                    r_d.state = ST_DST;
                end
            end
            ST_DST: begin
                cmd_valid = 1'b1;
                if (cmd_done) begin
                    r_d.dst   = cmd_rdata;
                    r_d.ptr   = r_q.ptr + STEP;
                    r_d.state = ST_CPRD;
                end
            end
            ST_CPRD: begin
                cmd_valid = 1'b1;
                cmd_addr  = r_q.src;
                if (cmd_done) begin
                    r_d.data  = cmd_rdata;
                    r_d.state = ST_CPWR;
                end
            end
            ST_CPWR: begin
                cmd_valid = 1'b1;
                cmd_we    = 1'b1;
                cmd_addr  = r_q.dst;
                if (cmd_done) begin
                    r_d.src    = r_q.src + STEP;
                    r_d.dst    = r_q.dst + STEP;
                    r_d.remain = r_q.remain - CW'(1);
                    r_d.state  = (r_q.remain == CW'(1)) ? ST_SIZE : ST_CPRD;
                end
            end
            ST_FIN: begin
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign done      = (r_q.state == ST_FIN);
    assign busy      = (r_q.state != ST_IDLE);
    assign jump_addr = r_q.entry;

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_jump_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(jump_addr));

    p_busy_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

    p_busy_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

// File: tb/section_loader_tb_top.sv
module section_loader_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] tbl_base = '0;
    logic        mem_req, mem_we, done, busy;
    logic [31:0] mem_addr, mem_wdata, jump_addr;
    logic        mem_gnt = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #5 clk = ~clk;

    section_loader dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .tbl_base(tbl_base),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .done(done), .jump_addr(jump_addr), .busy(busy)
    );

    typedef struct { bit we; logic [31:0] addr; logic [31:0] data; } op_t;

    logic [31:0] mem [0:1023];
    op_t         exp_q[$];
    int          n_cmp = 0, n_bad = 0, cyc = 0;
    bit          exp_busy = 0, done_arm = 0, run_over = 0, slow = 0, ended = 0;
    bit          rd_pend = 0;
    int          rd_cnt = 0;
    logic [31:0] rd_addr = '0, exp_entry = '0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    function automatic logic [31:0] rd(logic [31:0] a);
        return mem[a[11:2]];
    endfunction

    task automatic build(logic [31:0] base);
        logic [31:0] p, sz, ld, rn;
        int words;
        exp_q.delete();
        exp_q.push_back('{0, base, 0});
        exp_entry = rd(base);
        p = base + 4;
        forever begin
            exp_q.push_back('{0, p, 0});
            sz = rd(p);
            if (sz == 0) break;
            ld = rd(p + 4);
            rn = rd(p + 8);
            exp_q.push_back('{0, p + 4, 0});
            exp_q.push_back('{0, p + 8, 0});
            words = (sz + 3) / 4;
            for (int i = 0; i < words; i++) begin
                exp_q.push_back('{0, ld + 4*i, 0});
                exp_q.push_back('{1, rn + 4*i, rd(ld + 4*i)});
            end
            p = p + 12;
        end
    endtask

    // Reference model and memory responder, evaluated away from the active edge
    always @(negedge clk) begin
        bit exp_done_now;
        op_t o;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_gnt    = 1'b0;
        mem_rvalid = 1'b0;
        if (rst_n) begin
            exp_done_now = done_arm;
            done_arm     = 0;
            chk(done == exp_done_now, "R6", "done", 32'(done), 32'(exp_done_now));
            chk(busy == exp_busy, "R9", "busy", 32'(busy), 32'(exp_busy));
            if (exp_done_now) begin
                chk(jump_addr == exp_entry, "R6", "jump_addr", jump_addr, exp_entry);
                exp_busy = 0;
                run_over = 1;
            end else if (start && !exp_busy) begin
                build(tbl_base);
                exp_busy = 1;
            end
            if (rd_pend) begin
                chk(!mem_req, "R8", "request while read in flight", 32'(mem_req), 0);
                rd_cnt--;
                if (rd_cnt == 0) begin
                    rd_pend    = 0;
                    mem_rvalid = 1'b1;
                    mem_rdata  = rd(rd_addr);
                    if (exp_q.size() == 0) done_arm = 1;
                end
            end else if (mem_req && (!slow || lfsr[1:0] != 2'b00)) begin
                mem_gnt = 1'b1;
                if (exp_q.size() == 0) begin
                    chk(0, "R7", "unexpected access", mem_addr, 0);
                end else begin
                    o = exp_q.pop_front();
                    chk(mem_we == o.we, o.we ? "R3" : "R2", "direction", 32'(mem_we), 32'(o.we));
                    chk(mem_addr == o.addr, o.we ? "R3" : "R2", "address", mem_addr, o.addr);
                    if (o.we) begin
                        chk(mem_wdata == o.data, "R3", "write data", mem_wdata, o.data);
                        mem[mem_addr[11:2]] = mem_wdata;
                    end else begin
                        rd_pend = 1;
                        rd_addr = mem_addr;
                        rd_cnt  = slow ? 1 + int'(lfsr[4:3] % 3) : 1;
                    end
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !ended) begin
            ended = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic run(logic [31:0] base, bit with_second_start);
        @(posedge clk); #1;
        tbl_base = base;
        start    = 1'b1;
        @(posedge clk); #1;
        start    = 1'b0;
        run_over = 0;
        if (with_second_start) begin
            repeat (6) @(posedge clk);
            #1;
            tbl_base = 32'h180; // R7: different base, must be ignored
            start    = 1'b1;
            @(posedge clk); #1;
            start    = 1'b0;
        end
        while (!run_over) @(negedge clk);
        chk(exp_q.size() == 0, "R3", "pending expected ops", exp_q.size(), 0);
        repeat (3) @(posedge clk);
    endtask

    task automatic put(logic [31:0] a, logic [31:0] v);
        mem[a[11:2]] = v;
    endtask

    initial begin
        logic [31:0] orig;
        for (int i = 0; i < 1024; i++) mem[i] = 32'hA500_0000 + 32'(i);
        // Table A: sizes 8, 5, 1
        put(32'h100, 32'h0000_0C00);
        put(32'h104, 8);  put(32'h108, 32'h200); put(32'h10C, 32'h800);
        put(32'h110, 5);  put(32'h114, 32'h240); put(32'h118, 32'h880);
        put(32'h11C, 1);  put(32'h120, 32'h280); put(32'h124, 32'h8C0);
        put(32'h128, 0);
        // Table B: empty
        put(32'h180, 32'h0000_0ABC); put(32'h184, 0);
        // Table C: sizes 3, 4, 12
        put(32'h1C0, 32'h0000_0DE0);
        put(32'h1C4, 3);  put(32'h1C8, 32'h2C0); put(32'h1CC, 32'hA00);
        put(32'h1D0, 4);  put(32'h1D4, 32'h2D0); put(32'h1D8, 32'hA40);
        put(32'h1DC, 12); put(32'h1E0, 32'h2E0); put(32'h1E4, 32'hA80);
        put(32'h1E8, 0);

        repeat (3) @(negedge clk);
        chk(done == 0, "R1", "done in reset", 32'(done), 0);
        chk(busy == 0, "R1", "busy in reset", 32'(busy), 0);
        chk(mem_req == 0, "R1", "mem_req in reset", 32'(mem_req), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(mem_req == 0, "R1", "mem_req after reset", 32'(mem_req), 0);

        slow = 0;
        run(32'h100, 0);                   // R2 R3 R5 R6 fast handshakes
        orig = 32'hA500_0000 + 32'(32'h888 >> 2);
        chk(rd(32'h884) == rd(32'h244), "R5", "size 5 second word", rd(32'h884), rd(32'h244));
        chk(rd(32'h888) == orig, "R5", "past size 5 untouched", rd(32'h888), orig);
        orig = 32'hA500_0000 + 32'(32'h8C4 >> 2);
        chk(rd(32'h8C4) == orig, "R5", "past size 1 untouched", rd(32'h8C4), orig);

        slow = 1;
        run(32'h100, 0);                   // R8 stalls and read latency
        run(32'h180, 0);                   // R4 empty table, no writes
        chk(jump_addr == 32'h0000_0ABC, "R4", "entry of empty table", jump_addr, 32'h0000_0ABC);
        run(32'h1C0, 1);                   // R5 R7 rounding and ignored start
        orig = 32'hA500_0000 + 32'(32'hA04 >> 2);
        chk(rd(32'hA04) == orig, "R5", "past size 3 untouched", rd(32'hA04), orig);
        orig = 32'hA500_0000 + 32'(32'hA44 >> 2);
        chk(rd(32'hA44) == orig, "R5", "past size 4 untouched", rd(32'hA44), orig);
        chk(rd(32'hA88) == rd(32'h2E8), "R3", "size 12 last word", rd(32'hA88), rd(32'h2E8));
        chk(jump_addr == 32'h0000_0DE0, "R7", "entry kept after ignored start", jump_addr, 32'h0000_0DE0);

        if (!ended) begin
            ended = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule